// File: doc/BRIEF.md
# Banked Clock State Latch

This block sits on a shared backplane bus and holds the logic state of 24 clock-control lines, arranged as two banks of twelve. A controller broadcasts 16-bit command words together with a write strobe. Every board on the bus sees every word. Each board compares the address field of the word with its own setting on three board-address straps. Only the board whose straps match takes the word.

On a match, the twelve data bits are written into one bank, chosen by a single bank-select bit. The other bank keeps its previous value. A separate dual-update control input forces the data into both banks at once. This lets one command drive two identical sensor groups.

The write strobe is asynchronous to the system clock. It is passed through a synchronizer, and only its rising edge produces a one-cycle load request. The registered outputs feed analog level translators, which are not part of this block.

Top module: `bankclk_latch`

## Requirements
- R1: The command word is decoded as follows: bits 15..13 are the target board address, bit 12 is the bank select, and bits 11..0 are the clock state data.
- R2: A rising edge on `wr_strobe` causes exactly one load. The new outputs are visible after the third rising clock edge that follows the strobe edge.
- R3: A word is loaded only when bits 15..13 equal `addr_strap` bit for bit. Each strap pin reads 0 when its jumper is fitted and 1 when it is open. With straps `3'b001`, the board accepts words whose top nibble is 2 or 3.
- R4: With bank select 0 and `dual_upd` low, the data goes to `clk_state[11:0]`.
- R5: With bank select 1 and `dual_upd` low, the data goes to `clk_state[23:12]`.
- R6: In a single-bank load, the bank that is not addressed keeps its previous value.
- R7: With `dual_upd` high, an accepted word writes the same twelve data bits into both banks, whatever the bank-select bit says.
- R8: While `rst_n` is low, and after it is released, all 24 outputs are 0.
- R9: While the strobe is not rising, changes on `bus_word`, `dual_upd` or `addr_strap` have no effect on the outputs.
- R10: A falling edge of `wr_strobe`, and a strobe held high, cause no further load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_word | input | 16 | Backplane command word: address, bank select, data |
| wr_strobe | input | 1 | Asynchronous write strobe; its rising edge qualifies the word |
| addr_strap | input | 3 | Board-address strap levels (0 = fitted, 1 = open) |
| dual_upd | input | 1 | When high, an accepted word loads both banks |
| clk_state | output | 24 | Registered clock-control states; bank 1 in the upper 12 bits |

## Verification
The bank-select steering and the dual-update override both act on the same load pulse, so they can collide. The bench provokes this by drawing the bank bit at random while `dual_upd` is high. It then expects both halves of the output to carry the data, whatever the bank bit is. The same draws also combine `dual_upd` high with a mismatched address. Here the bench expects the outputs to stay unchanged, which shows that the override never bypasses the address filter.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

    // Kind of update a decoded command asks for
    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_SINGLE = 2'd1,
        UPD_ALL    = 2'd2
    } upd_mode_e;

endpackage

// File: rtl/bcl_edge_sync.sv
// Synchronizes an asynchronous level and emits a one-cycle pulse on its rise.
module bcl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    localparam int SH_W = STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SH_W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_pulse = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];

endmodule

// File: rtl/bcl_decode.sv
// Splits a command word and decides whether and where it is loaded.
module bcl_decode
    import bcl_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BSEL_W = 1,
    parameter int DATA_W = 12,
    localparam int WORD_W = ADDR_W + BSEL_W + DATA_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] strap,
    input  logic              dual,
    input  logic              fire,
    output upd_mode_e         mode,
    output logic [BSEL_W-1:0] bank_idx,
    output logic [DATA_W-1:0] data
);

    logic [ADDR_W-1:0] tgt_addr;
    logic              hit;

    always_comb begin
        tgt_addr = word[WORD_W-1 -: ADDR_W];
        bank_idx = word[DATA_W +: BSEL_W];
        data     = word[DATA_W-1:0];
        hit      = (tgt_addr == strap);
        if (!fire || !hit) begin
            mode = UPD_NONE;
        end else if (dual) begin
            mode = UPD_ALL;
        end else begin
            mode = UPD_SINGLE;
        end
    end

endmodule

// File: rtl/bcl_bank.sv
// One bank of clock-state flops with a write enable.
module bcl_bank #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.val = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.val;

endmodule

// File: rtl/bankclk_latch.sv
// Address-filtered, bank-steered latch for backplane clock-state words.
module bankclk_latch
    import bcl_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int NUM_BANKS   = 2,
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2,
    localparam int BSEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int WORD_W     = ADDR_W + BSEL_W + DATA_W,
    localparam int OUT_W      = NUM_BANKS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] bus_word,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] addr_strap,
    input  logic              dual_upd,
    output logic [OUT_W-1:0]  clk_state
);

    logic              ld_pulse;
    upd_mode_e         mode;
    logic [BSEL_W-1:0] bank_idx;
    logic [DATA_W-1:0] ld_data;

    bcl_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (wr_strobe),
        .rise_pulse (ld_pulse)
    );

    bcl_decode #(
        .ADDR_W (ADDR_W),
        .BSEL_W (BSEL_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .word     (bus_word),
        .strap    (addr_strap),
        .dual     (dual_upd),
        .fire     (ld_pulse),
        .mode     (mode),
        .bank_idx (bank_idx),
        .data     (ld_data)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic we;
        always_comb begin
            we = (mode == UPD_ALL) ||
                 ((mode == UPD_SINGLE) && (bank_idx == BSEL_W'(g)));
        end
        bcl_bank #(
            .DATA_W (DATA_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we),
            .din   (ld_data),
            .dout  (clk_state[g*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/bcl_checker.sv
module bcl_checker #(
    parameter int ADDR_W    = 3,
    parameter int NUM_BANKS = 2,
    parameter int DATA_W    = 12,
    parameter int BSEL_W    = 1,
    parameter int WORD_W    = 16,
    parameter int OUT_W     = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] bus_word,
    input logic [ADDR_W-1:0] addr_strap,
    input logic              dual_upd,
    input logic [OUT_W-1:0]  clk_state,
    input logic              ld_pulse
);

    logic              hit;
    logic [BSEL_W-1:0] sel;
    assign hit = (bus_word[WORD_W-1 -: ADDR_W] == addr_strap);
    assign sel = bus_word[DATA_W +: BSEL_W];

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pulse |=> !ld_pulse);

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_pulse |=> $stable(clk_state));

    // R3
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pulse && !hit) |=> $stable(clk_state));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bchk
        // R4 R5 R7
        bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_pulse && hit && (dual_upd || sel == BSEL_W'(b)))
            |=> clk_state[b*DATA_W +: DATA_W] == $past(bus_word[DATA_W-1:0]));
        // R6
        bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_pulse && hit && !dual_upd && sel != BSEL_W'(b))
            |=> $stable(clk_state[b*DATA_W +: DATA_W]));
    end

    // R8
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_zero_chk: assert (clk_state == '0);
        end
    end

endmodule

bind bankclk_latch bcl_checker #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS),
    .DATA_W    (DATA_W),
    .BSEL_W    (BSEL_W),
    .WORD_W    (WORD_W),
    .OUT_W     (OUT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_word   (bus_word),
    .addr_strap (addr_strap),
    .dual_upd   (dual_upd),
    .clk_state  (clk_state),
    .ld_pulse   (ld_pulse)
);

// File: tb/test_bankclk_latch.sv
module test_bankclk_latch;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_word = '0;
    logic        wr_strobe = 1'b0;
    logic [2:0]  addr_strap = 3'b001;
    logic        dual_upd = 1'b0;
    logic [23:0] clk_state;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [23:0] exp_st = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bankclk_latch i_bankclk_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_word   (bus_word),
        .wr_strobe  (wr_strobe),
        .addr_strap (addr_strap),
        .dual_upd   (dual_upd),
        .clk_state  (clk_state)
    );

    // Expected outputs after one accepted-or-rejected strobe
    function automatic logic [23:0] model(logic [23:0] cur, logic [15:0] w,
                                          logic dual, logic [2:0] strap);
        logic [23:0] nx = cur;
        if (w[15:13] == strap) begin
            if (dual) begin
                nx = {w[11:0], w[11:0]};
            end else if (w[12]) begin
                nx[23:12] = w[11:0];
            end else begin
                nx[11:0] = w[11:0];
            end
        end
        return nx;
    endfunction

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: clk_state=%06h expected=%06h", req, act, exp);
        end
    endtask

    // Drive a strobe rise, check after third clock edge, then release
    task automatic send(string req, logic [15:0] w, logic dual);
        @(negedge clk);
        bus_word  = w;
        dual_upd  = dual;
        wr_strobe = 1'b1;
        exp_st    = model(exp_st, w, dual, addr_strap);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(req, clk_state, exp_st);
        repeat (2) @(negedge clk);
        check({req, " R10 held-high"}, clk_state, exp_st);
        wr_strobe = 1'b0;
        repeat (4) @(negedge clk);
        check({req, " R10 fall"}, clk_state, exp_st);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R8
        check("R8 in reset", clk_state, 24'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 after reset", clk_state, 24'h0);

        // R2 latency: not yet visible after two edges
        @(negedge clk);
        bus_word  = 16'h2ABC;
        wr_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2 no early load", clk_state, 24'h0);
        @(negedge clk);
        exp_st = 24'h000ABC;
        check("R2 R4 R1 load bank0", clk_state, exp_st);
        wr_strobe = 1'b0;
        repeat (4) @(negedge clk);

        send("R5 R6 bank1 nibble3", 16'h3123, 1'b0);
        check("R6 bank0 kept", {12'h0, clk_state[11:0]}, 24'h000ABC);
        send("R4 R6 bank0 again", 16'h2F0F, 1'b0);
        send("R3 mismatch ignored", 16'h4FFF, 1'b0);
        send("R7 dual bank0 code", 16'h2555, 1'b1);
        send("R7 dual bank1 code", 16'h3AAA, 1'b1);
        send("R3 R7 dual mismatch", 16'hE777, 1'b1);

        // R9: bus activity without strobe
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bus_word   = 16'($urandom);
            dual_upd   = 1'($urandom);
            addr_strap = 3'b001;
            @(negedge clk);
            check("R9 idle bus change", clk_state, exp_st);
        end

        // R3 other strap setting
        addr_strap = 3'b110;
        send("R3 strap 110 accept", 16'hD0C3, 1'b0);
        send("R3 strap 110 reject", 16'h2FFF, 1'b0);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            addr_strap = 3'($urandom);
            if ($urandom_range(0, 3) != 0) w[15:13] = addr_strap;
            send("R3 R4 R5 R6 R7 random", w, 1'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule